// File: doc/BRIEF.md
# ALU Status Flag Generator

A 16-bit arithmetic and logic result stage that produces a result word and, alongside it, a registered set of six status flags: carry, parity, auxiliary carry, zero, sign and overflow. It sits after operand selection in an execution pipe. Each cycle it takes two operands, a 3-bit operation code, a byte/word size select and a flag-update enable. The result is combinational from the inputs. The flags are loaded on the next rising clock edge.

The operations are add, add-with-carry, subtract, subtract-with-borrow, AND, OR, XOR and a move that passes the second operand through. The carry-consuming operations take their carry or borrow input from the stored carry flag. A subtract stores its borrow in the carry flag. The half-carry is taken between bits 3 and 4. Parity is judged on the low byte of the result. The move never touches the flags. In byte mode the unit works on the low eight bits only, and carry, sign and overflow are taken from bit 7.

Top module: `alu_flag_unit`

## Requirements
- R1: Op codes are ADD=0, ADC=1, SUB=2, SBB=3, AND=4, OR=5, XOR=6, MOV=7. For ADD and ADC, `result_o` is a+b (ADC adds the stored carry flag). Carry (flags bit 0) is the carry out of the operand's most significant bit.
- R2: For SUB and SBB, `result_o` is a-b (SBB also subtracts the stored carry flag). Carry is set when a borrow is needed, so 0xB765-0xE952 gives 0xCE13 with carry=1, parity=0, auxiliary carry=0, zero=0, sign=1 and overflow=0.
- R3: Overflow (bit 5) is set by the arithmetic ops only when the signed result leaves the range of the operand size.
- R4: Auxiliary carry (bit 2) is the carry or borrow from bit 3 into bit 4 for the arithmetic ops.
- R5: Parity (bit 1) is 1 when the low 8 bits of the result hold an even count of ones, in both sizes.
- R6: Zero (bit 3) is 1 exactly when the result of the selected size is all zeros.
- R7: Sign (bit 4) copies bit 15 of the result, or bit 7 in byte mode.
- R8: AND, OR and XOR produce the bitwise result and clear carry, overflow and auxiliary carry.
- R9: MOV drives operand b onto `result_o` and leaves all six flags unchanged.
- R10: With `flag_en_i` low, no operation changes the flags.
- R11: With `byte_i` high, `result_o[15:8]` is zero, the upper operand bits have no effect, and carry and overflow are taken at bit 7.
- R12: While `rst_ni` is low, the flags are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_a_i | input | 16 | First operand |
| op_b_i | input | 16 | Second operand (subtrahend, move source) |
| op_i | input | 3 | Operation code |
| byte_i | input | 1 | 1 = byte size, 0 = word size |
| flag_en_i | input | 1 | Load the flags at the next edge |
| result_o | output | 16 | Combinational result |
| flags_o | output | 6 | Registered flags {ov, sign, zero, aux, parity, carry} |

## Verification
The bench builds the unit with its default parameters: a 16-bit word, an 8-bit byte and parity and a 4-bit nibble. These values put the stated subtraction example, signed wrap at both 0x7FFF and 0x7F, and the bit 3 to bit 4 half-carry within reach of directed vectors. Random vectors in both sizes then drive the carry chain from the stored carry through ADC and SBB. They also toggle the flag enable and the move against a behavioural model.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_AND = 3'd4,
    OP_OR  = 3'd5,
    OP_XOR = 3'd6,
    OP_MOV = 3'd7
  } alu_op_e;

  localparam int FLAG_N = 6;
  localparam int F_CY = 0;
  localparam int F_PA = 1;
  localparam int F_AC = 2;
  localparam int F_ZR = 3;
  localparam int F_SG = 4;
  localparam int F_OV = 5;
endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int WIDTH  = 16,
  parameter int LOW_W  = 8,
  parameter int NIB_W  = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  input  logic             cin_i,
  input  logic             byte_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cy_o,
  output logic             ac_o,
  output logic             ov_o
);
  logic [WIDTH:0] wide;
  logic [LOW_W:0] narrow;
  logic [NIB_W:0] nib;
  logic a_m, b_m, r_m;

  // borrow shows up as the extra top bit going high on wraparound
  always_comb begin
    if (sub_i) begin
      wide   = {1'b0, a_i} - {1'b0, b_i} - (WIDTH+1)'(cin_i);
      narrow = {1'b0, a_i[LOW_W-1:0]} - {1'b0, b_i[LOW_W-1:0]} - (LOW_W+1)'(cin_i);
      nib    = {1'b0, a_i[NIB_W-1:0]} - {1'b0, b_i[NIB_W-1:0]} - (NIB_W+1)'(cin_i);
    end else begin
      wide   = {1'b0, a_i} + {1'b0, b_i} + (WIDTH+1)'(cin_i);
      narrow = {1'b0, a_i[LOW_W-1:0]} + {1'b0, b_i[LOW_W-1:0]} + (LOW_W+1)'(cin_i);
      nib    = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_i[NIB_W-1:0]} + (NIB_W+1)'(cin_i);
    end
  end

  always_comb begin
    if (byte_i) begin
      res_o = {{(WIDTH-LOW_W){1'b0}}, narrow[LOW_W-1:0]};
      cy_o  = narrow[LOW_W];
      a_m   = a_i[LOW_W-1];
      b_m   = b_i[LOW_W-1];
      r_m   = narrow[LOW_W-1];
    end else begin
      res_o = wide[WIDTH-1:0];
      cy_o  = wide[WIDTH];
      a_m   = a_i[WIDTH-1];
      b_m   = b_i[WIDTH-1];
      r_m   = wide[WIDTH-1];
    end
    ac_o = nib[NIB_W];
    ov_o = sub_i ? ((a_m ^ b_m) & (r_m ^ a_m)) : (~(a_m ^ b_m) & (r_m ^ a_m));
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       sel_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    unique case (sel_i)
      2'd0:    res_o = a_i & b_i;
      2'd1:    res_o = a_i | b_i;
      2'd2:    res_o = a_i ^ b_i;
      default: res_o = b_i;
    endcase
  end
endmodule

// File: rtl/alu_flag_calc.sv
module alu_flag_calc #(
  parameter int WIDTH = 16,
  parameter int LOW_W = 8
) (
  input  logic [WIDTH-1:0] res_i,
  input  logic             byte_i,
  output logic             pa_o,
  output logic             zr_o,
  output logic             sg_o
);
  logic [LOW_W-1:0] par_chain;

  // parity always judged on the low byte
  genvar i;
  generate
    for (i = 0; i < LOW_W; i++) begin : g_par
      if (i == 0) begin : g_first
        assign par_chain[i] = res_i[0];
      end else begin : g_next
        assign par_chain[i] = par_chain[i-1] ^ res_i[i];
      end
    end
  endgenerate

  assign pa_o = ~par_chain[LOW_W-1];
  assign zr_o = byte_i ? (res_i[LOW_W-1:0] == '0) : (res_i == '0);
  assign sg_o = byte_i ? res_i[LOW_W-1] : res_i[WIDTH-1];
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int LOW_W = 8,
  parameter int NIB_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WIDTH-1:0]  op_a_i,
  input  logic [WIDTH-1:0]  op_b_i,
  input  logic [2:0]        op_i,
  input  logic              byte_i,
  input  logic              flag_en_i,
  output logic [WIDTH-1:0]  result_o,
  output logic [FLAG_N-1:0] flags_o
);
  localparam int HI_W = WIDTH - LOW_W;

  alu_op_e           op;
  logic              is_arith, is_sub, use_cin, cin;
  logic [WIDTH-1:0]  arith_res, logic_res, raw_res;
  logic              cy, ac, ov, pa, zr, sg;
  logic [FLAG_N-1:0] flags_q, flags_d;

  assign op       = alu_op_e'(op_i);
  assign is_arith = ~op_i[2];
  assign is_sub   = (op == OP_SUB) || (op == OP_SBB);
  assign use_cin  = (op == OP_ADC) || (op == OP_SBB);
  assign cin      = use_cin & flags_q[F_CY];

  alu_arith #(.WIDTH(WIDTH), .LOW_W(LOW_W), .NIB_W(NIB_W)) u_arith (
    .a_i(op_a_i), .b_i(op_b_i), .sub_i(is_sub), .cin_i(cin), .byte_i(byte_i),
    .res_o(arith_res), .cy_o(cy), .ac_o(ac), .ov_o(ov)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i(op_a_i), .b_i(op_b_i), .sel_i(op_i[1:0]), .res_o(logic_res)
  );

  always_comb begin
    raw_res = is_arith ? arith_res : logic_res;
    result_o = byte_i ? {{HI_W{1'b0}}, raw_res[LOW_W-1:0]} : raw_res;
  end

  alu_flag_calc #(.WIDTH(WIDTH), .LOW_W(LOW_W)) u_calc (
    .res_i(result_o), .byte_i(byte_i), .pa_o(pa), .zr_o(zr), .sg_o(sg)
  );

  always_comb begin
    flags_d       = '0;
    flags_d[F_CY] = is_arith & cy;
    flags_d[F_AC] = is_arith & ac;
    flags_d[F_OV] = is_arith & ov;
    flags_d[F_PA] = pa;
    flags_d[F_ZR] = zr;
    flags_d[F_SG] = sg;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          flags_q <= '0;
    else if (flag_en_i && op != OP_MOV)   flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] op_b_i,
  input logic [2:0]  op_i,
  input logic        byte_i,
  input logic        flag_en_i,
  input logic [15:0] result_o,
  input logic [5:0]  flags_o
);
  p_mov_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd7) |=> $stable(flags_o));

  p_mov_pass_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd7 && !byte_i) |-> (result_o == op_b_i));

  p_en_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_en_i |=> $stable(flags_o));

  p_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_en_i && op_i != 3'd7) |=> (flags_o[3] == ($past(result_o) == 16'h0)));

  p_sign_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_en_i && op_i != 3'd7) |=>
      (flags_o[4] == ($past(byte_i) ? $past(result_o[7]) : $past(result_o[15]))));

  p_logic_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_en_i && op_i[2] && op_i != 3'd7) |=> (flags_o[0] == 1'b0 && flags_o[2] == 1'b0 && flags_o[5] == 1'b0));

  p_parity_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_en_i && op_i != 3'd7) |=> (flags_o[1] == ($countones($past(result_o[7:0])) % 2 == 0)));

  p_byte_upper_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_i |-> (result_o[15:8] == 8'h00));

  always @(posedge clk_i)
    if (!rst_ni) p_reset_r12: assert (flags_o == 6'h00);
endmodule

bind alu_flag_unit alu_flag_unit_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_b_i(op_b_i), .op_i(op_i), .byte_i(byte_i),
  .flag_en_i(flag_en_i), .result_o(result_o), .flags_o(flags_o)
);

// File: tb/alu_flag_unit_tb.sv
module alu_flag_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic [2:0]  op = '0;
  logic        bsel = 1'b0, fen = 1'b0;
  logic [15:0] result;
  logic [5:0]  flags;

  int n_chk = 0, n_fail = 0;
  bit [5:0] mflags = '0;
  bit done = 0;

  always #2 clk = ~clk;

  alu_flag_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_a_i(op_a), .op_b_i(op_b), .op_i(op),
    .byte_i(bsel), .flag_en_i(fen), .result_o(result), .flags_o(flags)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference, integer arithmetic
  function automatic void model(input int a_in, input int b_in, input int opc, input bit bt,
                                input bit cf, output int res, output bit [5:0] f);
    int w, mask, a, b, c, full, ones;
    bit sa, sb, sr;
    w = bt ? 8 : 16;
    mask = (1 << w) - 1;
    a = a_in & mask;
    b = b_in & mask;
    c = (opc == 1 || opc == 3) ? int'(cf) : 0;
    f = '0;
    case (opc)
      0, 1: begin
        full = a + b + c;
        res = full & mask;
        f[0] = (full > mask);
        f[2] = (((a & 15) + (b & 15) + c) > 15);
      end
      2, 3: begin
        full = a - b - c;
        res = full & mask;
        f[0] = (a < b + c);
        f[2] = ((a & 15) < (b & 15) + c);
      end
      4: res = a & b;
      5: res = a | b;
      6: res = a ^ b;
      default: res = b;
    endcase
    sa = a[w-1]; sb = b[w-1]; sr = res[w-1];
    if (opc < 4) begin
      if (opc < 2) f[5] = (sa == sb) && (sr != sa);
      else         f[5] = (sa != sb) && (sr != sa);
    end
    ones = 0;
    for (int i = 0; i < 8; i++) ones += res[i];
    f[1] = (ones % 2 == 0);
    f[3] = (res == 0);
    f[4] = sr;
  endfunction

  task automatic apply(input int a, input int b, input int opc, input bit bt, input bit en,
                       input string tag);
    int er;
    bit [5:0] ef;
    @(negedge clk);
    op_a = a[15:0]; op_b = b[15:0]; op = opc[2:0]; bsel = bt; fen = en;
    model(a, b, opc, bt, mflags, er, ef);
    #1;
    check(result == er[15:0], {tag, " result"}, int'(result), er);
    @(posedge clk);
    #1;
    if (en && opc != 7) mflags = ef;
    check(flags == mflags, {tag, " flags"}, int'(flags), int'(mflags));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(flags == 6'h00, "R12 reset", int'(flags), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 worked example: CE13, C=1 P=0 A=0 Z=0 S=1 O=0
    apply('hB765, 'hE952, 2, 0, 1, "R2 sub example");
    check(flags == 6'b010001, "R2 example flags", int'(flags), 'h11);
    apply('h7FFF, 'h0001, 0, 0, 1, "R3 add overflow");
    apply('h8000, 'h0001, 2, 0, 1, "R3 sub overflow");
    apply('hFFFF, 'h0001, 0, 0, 1, "R1 R6 carry zero");
    apply('h0001, 'h0001, 1, 0, 1, "R1 adc carry in");
    apply('h000F, 'h0001, 0, 0, 1, "R4 aux carry");
    apply('h0010, 'h0001, 2, 0, 1, "R4 aux borrow");
    apply('h0000, 'h0001, 2, 0, 1, "R2 borrow");
    apply('h0005, 'h0002, 3, 0, 1, "R2 sbb borrow in");
    apply('h0200, 'h0100, 0, 0, 1, "R5 parity low byte zero");
    apply('h0007, 'h0000, 5, 0, 1, "R5 odd parity");
    apply('hF0F0, 'h0F0F, 4, 0, 1, "R8 and zero");
    apply('hF0F0, 'h0F0F, 6, 0, 1, "R7 R8 xor sign");
    apply('h1234, 'hABCD, 7, 0, 1, "R9 mov");
    apply('h7FFF, 'h0001, 0, 0, 0, "R10 enable low");
    apply('hAB80, 'h5580, 0, 1, 1, "R11 byte carry overflow");
    apply('hFF7F, 'h0001, 0, 1, 1, "R11 byte signed wrap");
    apply('h1200, 'h3400, 2, 1, 1, "R11 byte upper ignored");
    apply('hFF80, 'hFFFF, 7, 1, 1, "R9 R11 byte mov");

    for (int k = 0; k < 400; k++) begin
      int ra, rb, ro;
      bit rbt, ren;
      ra = int'($urandom_range(0, 65535));
      rb = int'($urandom_range(0, 65535));
      ro = int'($urandom_range(0, 7));
      rbt = 1'($urandom_range(0, 1));
      ren = ($urandom_range(0, 7) != 0);
      apply(ra, rb, ro, rbt, ren, "R1-7 random");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule